// File: doc/BRIEF.md
# Pattern-Based Detector Clock Sequencer

This block produces the clock levels for a detector and the convert strobes for its ADCs by replaying clock patterns stored in on-chip memory. Timing is set by a two-level program. A pattern memory holds state words, and each word gives the level of every clock line, a convert request and a flag that closes the pattern. A sequence memory holds a list of entries. Each entry names the address where a pattern starts, how long each of its states lasts and how many times it is replayed. It also carries two flags: one ends the list, and one makes the list start again from the top.

A host loads both memories through one write port while the block is idle. It then pulses `start`. The block walks the list from entry 0 and keeps `busy` high until the list ends or a stop request is honoured. A stop never cuts a pattern short. It is acted on when the pattern being played reaches its closing state. Whenever the block is idle, every clock line and the convert strobe are held low.

Top module: `clkpat_sequencer`

## Requirements
- R1: After reset, `busy`, every bit of `clk_out` and `convert` are 0.
- R2: A host write with `busy` low stores `host_data` at `host_addr`. `host_sel`=0 selects the pattern memory (low 20 data bits). `host_sel`=1 selects the sequence memory (low 6 address bits). A host write while `busy` is high changes neither memory.
- R3: A `start` sampled while idle raises `busy` on the next cycle. A `start` sampled while busy has no effect on the outputs.
- R4: A sequence entry holds the pattern start address in bits [9:0], the hold field in bits [17:10] and the replay count in bits [29:18]. Bit 30 is loop and bit 31 is end of list. Entries run in order, beginning with entry 0.
- R5: In a pattern word, bits [17:0] drive `clk_out[17:0]`, bit 18 requests a convert and bit 19 marks the last state of the pattern. Words play at rising addresses from the start address.
- R6: Each state stays on `clk_out` for hold+1 cycles. `convert` is high only in the first of those cycles, and only when bit 18 of the word is set.
- R7: A pattern is played replay+1 times before the next entry starts. A replay count of 0 means a single pass.
- R8: The first state appears 4 cycles after the edge that samples `start`. Between passes of one entry, the last state stays 2 extra cycles. Before a new entry begins, it stays 4 extra cycles.
- R9: When the last state of the final pass of an end-of-list entry without loop ends its hold, `clk_out` and `convert` drop to 0 and `busy` clears on that same edge.
- R10: When such an entry has loop set, execution returns to entry 0 instead of stopping.
- R11: A `stop` sampled while busy ends the run when the current pass reaches the end of its last state, even if replays or entries remain. The outputs drop as in R9. A `stop` sampled while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = pattern memory, 1 = sequence memory |
| host_addr | input | 10 | Host write address |
| host_data | input | 32 | Host write data |
| start | input | 1 | Begin running the list from entry 0 |
| stop | input | 1 | Request a stop at the end of the current pass |
| busy | output | 1 | High while a program is running |
| clk_out | output | 18 | Detector clock levels |
| convert | output | 1 | One-cycle ADC convert strobe |

## Verification
The assertions assume that reset is held for at least two cycles before it is released. They also assume that `start` and `stop` are level inputs sampled on the rising edge. Every entry used by a test points at a pattern that has a closing state, so each pass ends. The stimulus keeps to this: reset lasts four cycles, every pattern written has its bit 19 set on its final word, and inputs change only on the falling edge. A looping program is always ended by a stop.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Control phases of the sequencer
  typedef enum logic [2:0] {
    ST_IDLE,    // waiting for start, outputs low
    ST_FETCH,   // sequence memory read issued
    ST_DECODE,  // entry fields captured
    ST_FILL,    // first pattern word read issued
    ST_PLAY     // states being shown and held
  } sq_phase_e;

  // Host select encoding
  localparam logic SEL_PATTERN  = 1'b0;
  localparam logic SEL_SEQUENCE = 1'b1;

endpackage

// File: rtl/sq_ram.sv
// Simple dual-port memory: one write port, one registered read port with enable.
module sq_ram #(
  parameter int W  = 20,
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rq
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= mem[ra];
  end

endmodule

// File: rtl/sq_drive.sv
// Output register stage: latches a pattern word onto the clock lines,
// generates the one-cycle convert pulse and remembers the closing flag.
module sq_drive #(
  parameter int NCLK = 18,
  localparam int PW     = NCLK + 2,
  localparam int B_CONV = NCLK,
  localparam int B_LAST = NCLK + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,      // drop all lines (going idle)
  input  logic            arm,      // new pass: forget the closing flag
  input  logic            load,     // show the prefetched word
  input  logic [PW-1:0]   word,
  output logic [NCLK-1:0] lines,
  output logic            conv,
  output logic            last
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lines <= '0;
      conv  <= 1'b0;
      last  <= 1'b0;
    end else begin
      conv <= 1'b0;
      if (arm) last <= 1'b0;
      if (load) begin
        lines <= word[NCLK-1:0];
        conv  <= word[B_CONV];
        last  <= word[B_LAST];
      end
    end
  end

endmodule

// File: rtl/sq_ctrl.sv
// Sequence walker: fetches entries, counts holds and replays, decides
// what follows the closing state of each pass.
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int PAT_AW = 10,
  parameter int SEQ_AW = 6,
  parameter int RSP_W  = 8,
  parameter int REP_W  = 12,
  localparam int ENT_W    = PAT_AW + RSP_W + REP_W + 2,
  localparam int F_HOLD   = PAT_AW,
  localparam int F_REP    = PAT_AW + RSP_W,
  localparam int F_LOOP   = PAT_AW + RSP_W + REP_W,
  localparam int F_EOL    = F_LOOP + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [ENT_W-1:0]  entry,
  input  logic              last_shown,
  output logic              seq_re,
  output logic [SEQ_AW-1:0] seq_ra,
  output logic              pat_re,
  output logic [PAT_AW-1:0] pat_ra,
  output logic              show,
  output logic              arm,
  output logic              quiet,
  output logic              busy
);

  sq_phase_e           phase;
  logic [SEQ_AW-1:0]   idx;
  logic [PAT_AW-1:0]   rd_addr;
  logic [PAT_AW-1:0]   base_addr;
  logic [RSP_W-1:0]    hold_len;
  logic [RSP_W-1:0]    hold_cnt;
  logic [REP_W-1:0]    rep_left;
  logic                loop_f;
  logic                eol_f;
  logic                stop_pend;

  logic                hold_done;
  logic                pass_end;
  logic                stop_now;
  logic                go_idle;

  always_comb begin
    hold_done = (phase == ST_PLAY) && (hold_cnt == '0);
    show      = hold_done && !last_shown;
    pass_end  = hold_done && last_shown;
    stop_now  = stop_pend || stop;
    go_idle   = pass_end && (stop_now || ((rep_left == '0) && eol_f && !loop_f));
    arm       = (phase == ST_FILL);
    quiet     = go_idle;
    seq_re    = (phase == ST_FETCH);
    seq_ra    = idx;
    pat_re    = (phase == ST_FILL) || show;
    pat_ra    = rd_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= ST_IDLE;
      busy      <= 1'b0;
      idx       <= '0;
      rd_addr   <= '0;
      base_addr <= '0;
      hold_len  <= '0;
      hold_cnt  <= '0;
      rep_left  <= '0;
      loop_f    <= 1'b0;
      eol_f     <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (phase == ST_IDLE) stop_pend <= 1'b0;
      else if (stop)        stop_pend <= 1'b1;

      unique case (phase)
        ST_IDLE: begin
          if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            phase <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          phase <= ST_DECODE;
        end
        ST_DECODE: begin
          base_addr <= entry[PAT_AW-1:0];
          rd_addr   <= entry[PAT_AW-1:0];
          hold_len  <= entry[F_HOLD +: RSP_W];
          rep_left  <= entry[F_REP +: REP_W];
          loop_f    <= entry[F_LOOP];
          eol_f     <= entry[F_EOL];
          phase     <= ST_FILL;
        end
        ST_FILL: begin
          rd_addr  <= rd_addr + 1'b1;
          hold_cnt <= '0;
          phase    <= ST_PLAY;
        end
        ST_PLAY: begin
          if (!hold_done) begin
            hold_cnt <= hold_cnt - 1'b1;
          end else if (show) begin
            hold_cnt <= hold_len;
            rd_addr  <= rd_addr + 1'b1;
          end else if (go_idle) begin
            busy      <= 1'b0;
            stop_pend <= 1'b0;
            phase     <= ST_IDLE;
          end else if (rep_left != '0) begin
            rep_left <= rep_left - 1'b1;
            rd_addr  <= base_addr;
            phase    <= ST_FILL;
          end else begin
            idx   <= eol_f ? '0 : idx + 1'b1;
            phase <= ST_FETCH;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkpat_sequencer.sv
module clkpat_sequencer
  import sq_pkg::*;
#(
  parameter int NCLK   = 18,
  parameter int PAT_AW = 10,
  parameter int SEQ_AW = 6,
  parameter int RSP_W  = 8,
  parameter int REP_W  = 12,
  localparam int ENT_W = PAT_AW + RSP_W + REP_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [PAT_AW-1:0] host_addr,
  input  logic [ENT_W-1:0]  host_data,
  input  logic              start,
  input  logic              stop,
  output logic              busy,
  output logic [NCLK-1:0]   clk_out,
  output logic              convert
);

  localparam int PW = NCLK + 2;

  logic              pat_we, seq_we;
  logic              seq_re, pat_re;
  logic [SEQ_AW-1:0] seq_ra;
  logic [PAT_AW-1:0] pat_ra;
  logic [ENT_W-1:0]  seq_q;
  logic [PW-1:0]     pat_q;
  logic              show, arm, quiet, last_shown;

  // Host writes are accepted only while no program runs
  assign pat_we = host_we && (host_sel == SEL_PATTERN)  && !busy;
  assign seq_we = host_we && (host_sel == SEL_SEQUENCE) && !busy;

  sq_ram #(.W(PW), .AW(PAT_AW)) u_pat_mem (
    .clk (clk),
    .we  (pat_we),
    .wa  (host_addr),
    .wd  (host_data[PW-1:0]),
    .re  (pat_re),
    .ra  (pat_ra),
    .rq  (pat_q)
  );

  sq_ram #(.W(ENT_W), .AW(SEQ_AW)) u_seq_mem (
    .clk (clk),
    .we  (seq_we),
    .wa  (host_addr[SEQ_AW-1:0]),
    .wd  (host_data),
    .re  (seq_re),
    .ra  (seq_ra),
    .rq  (seq_q)
  );

  sq_ctrl #(
    .PAT_AW (PAT_AW),
    .SEQ_AW (SEQ_AW),
    .RSP_W  (RSP_W),
    .REP_W  (REP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .stop       (stop),
    .entry      (seq_q),
    .last_shown (last_shown),
    .seq_re     (seq_re),
    .seq_ra     (seq_ra),
    .pat_re     (pat_re),
    .pat_ra     (pat_ra),
    .show       (show),
    .arm        (arm),
    .quiet      (quiet),
    .busy       (busy)
  );

  sq_drive #(.NCLK(NCLK)) u_drive (
    .clk   (clk),
    .rst   (rst),
    .clr   (quiet),
    .arm   (arm),
    .load  (show),
    .word  (pat_q),
    .lines (clk_out),
    .conv  (convert),
    .last  (last_shown)
  );

endmodule

// File: rtl/clkpat_sequencer_chk.sv
module clkpat_sequencer_chk #(
  parameter int NCLK = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic [NCLK-1:0] clk_out,
  input logic            convert
);

  // R9 / R11: an idle block drives every line low
  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (clk_out == '0) && !convert);

  // R3: start seen while idle makes the block busy next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R6: a convert pulse only comes from a running program
  p_conv_busy_r6: assert property (@(posedge clk) disable iff (rst)
    convert |-> busy);

  // R11: clock levels move only while running or on the edge that ends a run
  p_lines_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_out) |-> (busy || $fell(busy)));

endmodule

bind clkpat_sequencer clkpat_sequencer_chk #(.NCLK(NCLK)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .clk_out (clk_out),
  .convert (convert)
);

// File: tb/clkpat_sequencer_test.sv
`timescale 1ns/1ps
module clkpat_sequencer_test;

  localparam int CAP = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic        host_sel = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_data = '0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        busy;
  logic [17:0] clk_out;
  logic        convert;

  always #4 clk = ~clk;

  clkpat_sequencer uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_data(host_data), .start(start), .stop(stop),
    .busy(busy), .clk_out(clk_out), .convert(convert)
  );

  // Reference memory images, updated only by accepted writes
  logic [19:0] pat_m [1024];
  logic [31:0] seq_m [64];

  // Expected per-cycle outputs, index i = after edge (start edge + i)
  logic        q_busy [$];
  logic [17:0] q_clk  [$];
  logic        q_cv   [$];

  int  vec_n = 0;
  int  bad_n = 0;
  bit  done  = 0;

  function automatic logic [31:0] ent(int sa, int hold, int rep, bit lp, bit eol);
    logic [31:0] e;
    e = '0;
    e[9:0]   = sa[9:0];
    e[17:10] = hold[7:0];
    e[29:18] = rep[11:0];
    e[30]    = lp;
    e[31]    = eol;
    return e;
  endfunction

  function automatic logic [31:0] pw(logic [17:0] lv, bit cv, bit fin);
    return {12'h000, fin, cv, lv};
  endfunction

  function automatic void push(logic b, logic [17:0] c, logic cv);
    q_busy.push_back(b);
    q_clk.push_back(c);
    q_cv.push_back(cv);
  endfunction

  // Build the expected trace from the requirements (R4..R11)
  function automatic void gen(int stop_at);
    logic [17:0] cur;
    logic [31:0] e;
    logic [19:0] w;
    int entry, a, d, reps, hold;
    bit fin;
    cur = '0; entry = 0; fin = 0;
    q_busy.delete(); q_clk.delete(); q_cv.delete();
    repeat (4) push(1'b1, cur, 1'b0);                 // R8 start latency
    while (!fin) begin
      e    = seq_m[entry];
      reps = int'(e[29:18]);
      hold = int'(e[17:10]);
      for (int p = 0; p <= reps && !fin; p++) begin
        a = int'(e[9:0]);
        do begin
          w = pat_m[a];
          push(1'b1, w[17:0], w[18]);
          cur = w[17:0];
          repeat (hold) push(1'b1, cur, 1'b0);
          a = (a + 1) % 1024;
        end while (!w[19] && q_busy.size() < CAP);
        d = q_busy.size();
        if (d >= CAP) fin = 1;
        else if (stop_at > 0 && stop_at <= d) begin
          push(1'b0, '0, 1'b0);
          fin = 1;
        end else if (p < reps) begin
          push(1'b1, cur, 1'b0);
          push(1'b1, cur, 1'b0);
        end
      end
      if (!fin) begin
        if (e[31] && !e[30]) begin
          push(1'b0, '0, 1'b0);
          fin = 1;
        end else begin
          entry = e[31] ? 0 : (entry + 1) % 64;
          repeat (4) push(1'b1, cur, 1'b0);
        end
      end
    end
  endfunction

  task automatic chk(string tag, logic b, logic [17:0] c, logic cv);
    vec_n++;
    if (busy !== b || clk_out !== c || convert !== cv) begin
      bad_n++;
      $display("FAIL %s @%0t: got busy=%0b clk=%h cv=%0b, expected busy=%0b clk=%h cv=%0b",
               tag, $time, busy, clk_out, convert, b, c, cv);
    end
  endtask

  task automatic hwrite(bit s, int ad, logic [31:0] dt);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_addr = ad[9:0]; host_data = dt;
    if (s) seq_m[ad % 64] = dt;
    else   pat_m[ad] = dt[19:0];
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // Start a run and compare every cycle. stop_at / again_at / wr_at are
  // trace indices at whose edge the input is sampled (0 = unused).
  task automatic run(string tag, int stop_at, int again_at, int wr_at);
    gen(stop_at);
    @(negedge clk);
    start = 1'b1;
    foreach (q_busy[i]) begin
      @(negedge clk);
      start = 1'b0; stop = 1'b0; host_we = 1'b0;
      chk(tag, q_busy[i], q_clk[i], q_cv[i]);
      if (i + 1 == stop_at)  stop  = 1'b1;
      if (i + 1 == again_at) start = 1'b1;
      if (i + 1 == wr_at) begin            // R2: ignored, model untouched
        host_we = 1'b1; host_sel = 1'b0; host_addr = 10'd0; host_data = pw(18'h0, 1'b0, 1'b1);
      end
      if (i == wr_at && wr_at > 0) begin
        host_we = 1'b1; host_sel = 1'b1; host_addr = 10'd0; host_data = ent(500, 0, 0, 1'b0, 1'b1);
      end
    end
    repeat (3) begin
      @(negedge clk);
      start = 1'b0; stop = 1'b0; host_we = 1'b0;
      chk(tag, 1'b0, '0, 1'b0);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad_n++;
      $display("FAIL watchdog (R1..R11 run incomplete): got timeout, expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset", 1'b0, '0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 1'b0, '0, 1'b0);

    // Patterns
    hwrite(0, 0,   pw(18'h00001, 1'b1, 1'b0));
    hwrite(0, 1,   pw(18'h00003, 1'b0, 1'b0));
    hwrite(0, 2,   pw(18'h3FFFF, 1'b1, 1'b1));
    hwrite(0, 100, pw(18'h2AAAA, 1'b0, 1'b0));
    hwrite(0, 101, pw(18'h15555, 1'b1, 1'b1));
    hwrite(0, 500, pw(18'h0F0F0, 1'b1, 1'b1));

    // Single entry, one-cycle states, end of list
    hwrite(1, 0, ent(0, 0, 0, 1'b0, 1'b1));
    run("R5 R6 R8 R9 single entry", 0, 0, 0);

    // Start while busy ignored; stop while idle ignored
    run("R3 start while busy", 0, 5, 0);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    run("R11 stop while idle", 0, 0, 0);

    // Three entries with holds and replays
    hwrite(1, 0, ent(0,   2, 1, 1'b0, 1'b0));
    hwrite(1, 1, ent(100, 0, 2, 1'b0, 1'b0));
    hwrite(1, 2, ent(500, 3, 0, 1'b0, 1'b1));
    run("R4 R6 R7 R8 multi entry", 0, 0, 0);

    // Writes while busy must not land
    run("R2 busy write", 0, 0, 10);
    run("R2 after busy write", 0, 0, 0);

    // Loop back to entry 0, ended by stop
    hwrite(1, 0, ent(100, 1, 0, 1'b0, 1'b0));
    hwrite(1, 1, ent(500, 0, 1, 1'b1, 1'b1));
    run("R10 R11 loop then stop", 40, 0, 0);

    // Stop during replays ends after the current pass
    hwrite(1, 0, ent(0, 1, 5, 1'b1, 1'b1));
    run("R7 R11 stop mid replays", 6, 0, 0);

    finish_up();
  end

endmodule